// File: doc/BRIEF.md
# I2C Trim-Code Slave

This block is a single-byte I2C target that owns a 7-bit calibration code. It runs from a fast system clock. SCL and SDA are synchronised and then glitch-filtered. START and STOP are found on the filtered lines, and the block answers only to the 7-bit bus address 1001111.

A read returns the live code. A write carries one data byte. The upper seven bits of that byte are the new value. Bit 0 selects the target: either the volatile code register, or a request to a non-volatile store that lies outside this block. Data writes are refused with NACK in two cases: while the write-enable input is low, or while the external programming cycle reports busy.

The SDA output is an open-drain enable: when high, the pad pulls SDA low. The slave never stretches SCL.

Top module: `i2c_trim_slave`

## Requirements
- R1: The first byte after START is the address in bits 7..1 (MSB first) and the direction in bit 0 (1 = read, 0 = write). Only address 1001111 is acknowledged. Any other address gets NACK, and the bus is then ignored until the next START or STOP: no ACK, no strobe, no code change.
- R2: A write data byte with bit 0 = 1 is acknowledged. `code` takes bits 7..1 and `code_wr` pulses high for exactly one clock. `code` changes at no other time.
- R3: A write data byte with bit 0 = 0 is acknowledged. `prog_req` pulses for one clock with `prog_data` = bits 7..1, and `code` is left unchanged. `code_wr` and `prog_req` are never high together.
- R4: While `wr_en` is low at the end of a write data byte, that byte gets NACK and produces no strobe and no code change.
- R5: While `prog_busy` is high at the end of a write data byte, that byte gets NACK and produces no strobe and no code change.
- R6: After an acknowledged read address, the slave sends the code MSB first on bits 7..1 and 0 on bit 8, changing SDA only after falling SCL edges. On a master ACK it sends the code again. On a master NACK it releases SDA and waits for STOP.
- R7: A START seen in any phase, including part-way through a byte, abandons that phase and restarts address reception. The partial byte has no effect.
- R8: A level on SCL or SDA that lasts fewer than `FILT_CYCLES` system clocks is ignored. With the default of 6 at 100 MHz, this covers spikes up to 50 ns.
- R9: After reset, `code` equals `RESET_CODE` (default 7'h40), and `sda_oe`, `code_wr` and `prog_req` are low.
- R10: Every output reacts exactly `FILT_CYCLES`+3 clocks after the SCL or SDA transition that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pad input |
| sda_i | input | 1 | SDA pad input (wired bus level) |
| sda_oe | output | 1 | High pulls SDA low |
| wr_en | input | 1 | Write enable; low blocks data writes |
| prog_busy | input | 1 | Non-volatile programming in progress |
| code | output | 7 | Live calibration code |
| code_wr | output | 1 | One-clock strobe when `code` is loaded |
| prog_req | output | 1 | One-clock request to program non-volatile memory |
| prog_data | output | 7 | Value to program, valid with `prog_req` |

## Verification
Every result of this block, whether an ACK, a read bit, a strobe or a code change, is due exactly `FILT_CYCLES`+3 clocks after the bench's SCL or SDA edge that causes it. Two synchroniser stages, the filter count, the filter output register and the state register make up that delay. The bench's reference model applies each expected change at that same cycle and compares all outputs on every falling clock edge, so an early or late response counts as a mismatch. Bus-level ACK and read-data samples are also taken late in each SCL high phase, the way a master would see them.

// File: rtl/i2c_trim_pkg.sv
package i2c_trim_pkg;

    localparam int CODE_W = 7;
    localparam int BYTE_W = CODE_W + 1;
    localparam int BCNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [BCNT_W-1:0]   nbits;
        logic [BYTE_W-1:0]   sreg;
        logic                is_rd;
        logic                host_ack;
        logic                drive;
        logic [CODE_W-1:0]   code;
        logic                code_wr;
        logic                prog_req;
        logic [CODE_W-1:0]   prog_data;
    } slv_st_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int   STABLE    = 6,
    parameter logic RESET_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(STABLE + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          level;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[0], line_i};
        if (flt_q.sync[1] == flt_q.level) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == CW'(STABLE - 1)) begin
            flt_d.level = flt_q.sync[1];
            flt_d.cnt   = '0;
        end else begin
            flt_d.cnt = flt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '{sync: {2{RESET_LVL}}, level: RESET_LVL, cnt: '0};
        end else begin
            flt_q <= flt_d;
        end
    end

    assign line_o = flt_q.level;

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl_p = scl;
        prev_d.sda_p = sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '{scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            prev_q <= prev_d;
        end
    end

    assign scl_rise = scl & ~prev_q.scl_p;
    assign scl_fall = ~scl & prev_q.scl_p;
    // SDA moves while SCL stays high: a bus condition, not data
    assign start_c  = scl & prev_q.scl_p & prev_q.sda_p & ~sda;
    assign stop_c   = scl & prev_q.scl_p & ~prev_q.sda_p & sda;

endmodule

// File: rtl/i2c_trim_fsm.sv
module i2c_trim_fsm
    import i2c_trim_pkg::*;
#(
    parameter logic [CODE_W-1:0] DEV_ADDR   = 7'b1001111,
    parameter logic [CODE_W-1:0] RESET_CODE = 7'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_f,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_c,
    input  logic              stop_c,
    input  logic              wr_en,
    input  logic              prog_busy,
    output logic              sda_oe,
    output logic [CODE_W-1:0] code,
    output logic              code_wr,
    output logic              prog_req,
    output logic [CODE_W-1:0] prog_data
);
    slv_st_t           st_d, st_q;
    logic [BYTE_W-1:0] tx_view;
    logic              byte_done;

    assign tx_view   = st_q.sreg << st_q.nbits;
    assign byte_done = (st_q.nbits == BCNT_W'(BYTE_W));

    always_comb begin
        st_d          = st_q;
        st_d.code_wr  = 1'b0;
        st_d.prog_req = 1'b0;

        if (start_c) begin
            st_d.phase = ST_ADDR;
            st_d.nbits = '0;
            st_d.drive = 1'b0;
        end else if (stop_c) begin
            st_d.phase = ST_IDLE;
            st_d.drive = 1'b0;
        end else if (scl_rise) begin
            case (st_q.phase)
                ST_ADDR, ST_WR: begin
                    if (!byte_done) begin
                        st_d.sreg  = {st_q.sreg[BYTE_W-2:0], sda_f};
                        st_d.nbits = st_q.nbits + 1'b1;
                    end
                end
                ST_RD:     st_d.nbits    = st_q.nbits + 1'b1;
                ST_RD_ACK: st_d.host_ack = ~sda_f;
                default: ;
            endcase
        end else if (scl_fall) begin
            case (st_q.phase)
                ST_ADDR: begin
                    if (byte_done) begin
                        if (st_q.sreg[BYTE_W-1:1] == DEV_ADDR) begin
                            st_d.phase = ST_ADDR_ACK;
                            st_d.is_rd = st_q.sreg[0];
                            st_d.drive = 1'b1;
                        end else begin
                            st_d.phase = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    st_d.nbits = '0;
                    if (st_q.is_rd) begin
                        st_d.phase = ST_RD;
                        st_d.sreg  = {st_q.code, 1'b0};
                        st_d.drive = ~st_q.code[CODE_W-1];
                    end else begin
                        st_d.phase = ST_WR;
                        st_d.drive = 1'b0;
                    end
                end
                ST_WR: begin
                    if (byte_done) begin
                        st_d.phase = ST_WR_ACK;
                        if (wr_en && !prog_busy) begin
                            st_d.drive = 1'b1;
                            if (st_q.sreg[0]) begin
                                st_d.code    = st_q.sreg[BYTE_W-1:1];
                                st_d.code_wr = 1'b1;
                            end else begin
                                st_d.prog_data = st_q.sreg[BYTE_W-1:1];
                                st_d.prog_req  = 1'b1;
                            end
                        end
                    end
                end
                ST_WR_ACK: begin
                    st_d.phase = ST_IDLE;
                    st_d.drive = 1'b0;
                end
                ST_RD: begin
                    if (byte_done) begin
                        st_d.phase = ST_RD_ACK;
                        st_d.drive = 1'b0;
                    end else begin
                        st_d.drive = ~tx_view[BYTE_W-1];
                    end
                end
                ST_RD_ACK: begin
                    if (st_q.host_ack) begin
                        st_d.phase = ST_RD;
                        st_d.nbits = '0;
                        st_d.sreg  = {st_q.code, 1'b0};
                        st_d.drive = ~st_q.code[CODE_W-1];
                    end else begin
                        st_d.phase = ST_IDLE;
                        st_d.drive = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: ST_IDLE, nbits: '0, sreg: '0, is_rd: 1'b0,
                      host_ack: 1'b0, drive: 1'b0, code: RESET_CODE,
                      code_wr: 1'b0, prog_req: 1'b0, prog_data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe    = st_q.drive;
    assign code      = st_q.code;
    assign code_wr   = st_q.code_wr;
    assign prog_req  = st_q.prog_req;
    assign prog_data = st_q.prog_data;

endmodule

// File: rtl/i2c_trim_slave.sv
module i2c_trim_slave
    import i2c_trim_pkg::*;
#(
    parameter int                FILT_CYCLES = 6,
    parameter logic [CODE_W-1:0] DEV_ADDR    = 7'b1001111,
    parameter logic [CODE_W-1:0] RESET_CODE  = 7'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              wr_en,
    input  logic              prog_busy,
    output logic [CODE_W-1:0] code,
    output logic              code_wr,
    output logic              prog_req,
    output logic [CODE_W-1:0] prog_data
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, clean_lines;
    logic scl_rise, scl_fall, start_c, stop_c;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        i2c_line_filter #(
            .STABLE   (FILT_CYCLES),
            .RESET_LVL(1'b1)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .line_o(clean_lines[g])
        );
    end

    i2c_bus_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (clean_lines[0]),
        .sda     (clean_lines[1]),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_c (start_c),
        .stop_c  (stop_c)
    );

    i2c_trim_fsm #(
        .DEV_ADDR  (DEV_ADDR),
        .RESET_CODE(RESET_CODE)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_f    (clean_lines[1]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c),
        .wr_en    (wr_en),
        .prog_busy(prog_busy),
        .sda_oe   (sda_oe),
        .code     (code),
        .code_wr  (code_wr),
        .prog_req (prog_req),
        .prog_data(prog_data)
    );

endmodule

// File: rtl/i2c_trim_checker.sv
module i2c_trim_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_event,
    input logic       wr_en,
    input logic       prog_busy,
    input logic       sda_oe,
    input logic [6:0] code,
    input logic       code_wr,
    input logic       prog_req
);
    // R3: never a register load and a programming request together
    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({code_wr, prog_req}));

    // R2: the code register moves only with its strobe
    assert_code_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code) |-> code_wr);

    // R4: no effect unless writes were enabled
    assert_wp_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_wr || prog_req) |-> $past(wr_en));

    // R5: no effect while programming is busy
    assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_wr || prog_req) |-> !$past(prog_busy));

    // R6: SDA drive changes only after an SCL fall or a bus condition
    assert_drive_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(bus_event));
endmodule

bind i2c_trim_slave i2c_trim_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_event(scl_fall | start_c | stop_c),
    .wr_en    (wr_en),
    .prog_busy(prog_busy),
    .sda_oe   (sda_oe),
    .code     (code),
    .code_wr  (code_wr),
    .prog_req (prog_req)
);

// File: tb/i2c_trim_slave_test.sv
`timescale 1ns/1ps
module i2c_trim_slave_test;
    localparam int FILT = 6;
    localparam int LAT  = FILT + 3;   // R10: reaction delay in clocks
    localparam int H    = 40;
    localparam int Q    = 20;
    localparam int G    = FILT - 2;   // spike width for R8

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic wr_en = 1'b1, prog_busy = 1'b0;
    logic sda_oe, code_wr, prog_req;
    logic [6:0] code, prog_data;
    wire sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2c_trim_slave #(.FILT_CYCLES(FILT)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .wr_en(wr_en), .prog_busy(prog_busy),
        .code(code), .code_wr(code_wr), .prog_req(prog_req), .prog_data(prog_data)
    );

    int checks = 0, errors = 0, cyc = 0;
    logic mon_on = 1'b0;
    logic exp_oe = 1'b0, exp_wr = 1'b0, exp_prog = 1'b0;
    logic [6:0] exp_code = 7'h40, exp_pdata = 7'h00;
    string tag = "R9";

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
            finish_run();
        end
    end

    // reference model comparison on every clock (R10 timing included)
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            checks++;
            if ({sda_oe, code, code_wr, prog_req} !== {exp_oe, exp_code, exp_wr, exp_prog}
                || (prog_req && prog_data !== exp_pdata)) begin
                errors++;
                $display("FAIL %s R10 t=%0t: oe/code/wr/req/pdata = %b/%h/%b/%b/%h expected %b/%h/%b/%b/%h",
                         tag, $time, sda_oe, code, code_wr, prog_req, prog_data,
                         exp_oe, exp_code, exp_wr, exp_prog, exp_pdata);
            end
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic put_sda(input logic v);
        @(negedge clk); sda_m = v;
        repeat (Q) @(posedge clk);
    endtask

    task automatic rise();
        @(negedge clk); scl_m = 1'b1;
        repeat (H) @(posedge clk);
    endtask

    task automatic fall(input logic n_oe, input bit w, input bit p, input logic [6:0] v);
        @(negedge clk); scl_m = 1'b0;
        repeat (LAT) @(posedge clk);
        #1;
        exp_oe = n_oe;
        if (w) begin exp_code = v; exp_wr = 1'b1; end
        if (p) begin exp_pdata = v; exp_prog = 1'b1; end
        @(posedge clk); #1;
        exp_wr = 1'b0; exp_prog = 1'b0;
        repeat (H - LAT - 2) @(posedge clk);
    endtask

    task automatic spike_scl();
        @(negedge clk); scl_m = 1'b1;
        repeat (G) @(posedge clk);
        @(negedge clk); scl_m = 1'b0;
        repeat (Q) @(posedge clk);
    endtask

    task automatic spike_sda();
        logic keep;
        keep = sda_m;
        @(negedge clk); sda_m = ~keep;
        repeat (G) @(posedge clk);
        @(negedge clk); sda_m = keep;
        repeat (Q) @(posedge clk);
    endtask

    task automatic bus_start();
        put_sda(1'b1);
        rise();
        @(negedge clk); sda_m = 1'b0;
        repeat (H) @(posedge clk);
        fall(1'b0, 0, 0, 7'h0);
    endtask

    task automatic bus_stop();
        put_sda(1'b0);
        rise();
        @(negedge clk); sda_m = 1'b1;
        repeat (H) @(posedge clk);
    endtask

    task automatic bit_out(input logic b);
        put_sda(b);
        rise();
        fall(1'b0, 0, 0, 7'h0);
    endtask

    task automatic tx_byte(input logic [7:0] b, input logic last_oe, input bit w,
                           input bit p, input bit spikes);
        for (int i = 7; i >= 1; i--) begin
            put_sda(b[i]);
            rise();
            if (spikes && i == 6) spike_sda();
            fall(1'b0, 0, 0, 7'h0);
            if (spikes && i == 5) spike_scl();
        end
        put_sda(b[0]);
        rise();
        fall(last_oe, w, p, b[7:1]);
    endtask

    task automatic ack_slot(input logic want_ack, input logic n_oe);
        put_sda(1'b1);
        rise();
        chk(sda_bus == ~want_ack, "ack slot bus level", sda_bus, ~want_ack);
        fall(n_oe, 0, 0, 7'h0);
    endtask

    task automatic write_txn(input logic [6:0] addr, input logic [7:0] data, input bit spikes);
        bit aok, acc;
        aok = (addr == 7'b1001111);
        acc = aok && wr_en && !prog_busy;
        bus_start();
        tx_byte({addr, 1'b0}, aok, 0, 0, spikes);
        ack_slot(aok, 1'b0);
        tx_byte(data, acc, acc && data[0], acc && !data[0], 0);
        ack_slot(acc, 1'b0);
        bus_stop();
    endtask

    task automatic read_txn(input int nbytes);
        logic [7:0] rb;
        rb = {exp_code, 1'b0};
        bus_start();
        tx_byte(8'h9F, 1'b1, 0, 0, 0);
        ack_slot(1'b1, ~rb[7]);
        for (int k = 0; k < nbytes; k++) begin
            bit last;
            last = (k == nbytes - 1);
            for (int i = 7; i >= 0; i--) begin
                rise();
                chk(sda_bus == rb[i], "read bit", sda_bus, rb[i]);
                fall((i > 0) ? ~rb[i-1] : 1'b0, 0, 0, 7'h0);
            end
            put_sda(last ? 1'b1 : 1'b0);
            rise();
            fall(last ? 1'b0 : ~rb[7], 0, 0, 7'h0);
            put_sda(1'b1);
        end
        bus_stop();
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        tag = "R9";
        chk(code == 7'h40 && !sda_oe && !code_wr && !prog_req, "reset state",
            {sda_oe, code_wr, prog_req, code}, 10'h040);
        mon_on = 1'b1;

        tag = "R2";
        write_txn(7'b1001111, {7'h15, 1'b1}, 0);
        chk(code == 7'h15, "code after load", code, 7'h15);

        tag = "R6";
        read_txn(1);

        tag = "R3";
        write_txn(7'b1001111, {7'h2A, 1'b0}, 0);
        chk(code == 7'h15, "code kept on program request", code, 7'h15);

        tag = "R5";
        prog_busy = 1'b1;
        write_txn(7'b1001111, {7'h33, 1'b1}, 0);
        write_txn(7'b1001111, {7'h34, 1'b0}, 0);
        chk(code == 7'h15, "code kept while busy", code, 7'h15);
        prog_busy = 1'b0;

        tag = "R4";
        wr_en = 1'b0;
        write_txn(7'b1001111, {7'h44, 1'b1}, 0);
        write_txn(7'b1001111, {7'h45, 1'b0}, 0);
        chk(code == 7'h15, "code kept while protected", code, 7'h15);
        wr_en = 1'b1;

        tag = "R1";
        write_txn(7'b1001110, {7'h11, 1'b1}, 0);
        write_txn(7'b0001111, {7'h12, 1'b1}, 0);
        chk(code == 7'h15, "code kept on foreign address", code, 7'h15);

        tag = "R2";
        write_txn(7'b1001111, {7'h7F, 1'b1}, 0);
        chk(code == 7'h7F, "full-scale load", code, 7'h7F);
        tag = "R6";
        read_txn(2);
        tag = "R2";
        write_txn(7'b1001111, 8'h01, 0);
        chk(code == 7'h00, "zero-scale load", code, 7'h00);
        tag = "R6";
        read_txn(3);

        tag = "R7";
        bus_start();
        tx_byte(8'h9E, 1'b1, 0, 0, 0);
        ack_slot(1'b1, 1'b0);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_start();
        bit_out(1'b0); bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
        write_txn(7'b1001111, {7'h26, 1'b1}, 0);
        chk(code == 7'h26, "load after repeated start", code, 7'h26);

        tag = "R8";
        write_txn(7'b1001111, {7'h5A, 1'b1}, 1);
        chk(code == 7'h5A, "load with spikes on both lines", code, 7'h5A);
        read_txn(1);

        repeat (20) @(posedge clk);
        finish_run();
    end
endmodule